// File: doc/BRIEF.md
# Weighted Ensemble Voting Unit

This block merges the answers of several parallel binarized subnetworks that have each finished processing the same frame. Every subnetwork delivers one signed fixed-point regression value (a steering estimate) and one class bit (collision or clear). The unit takes the per-model results one at a time. It keeps two running sums, each scaled by a programmable per-model weight, and at the end of the frame it reports one combined steering value and one combined collision decision.

The soft path multiplies each regression value by its model's weight and adds the products. It then divides the total by the number of models and by the weight scale, which gives a weighted average. The hard path adds the weight of every model that votes "collision" and also adds the weight of every model. It declares a collision when the voting weight reaches half of the total weight, so the threshold stays correct even when the weights do not sum to one. Weights are unsigned Q0.8 values and are held in registers that can be loaded one model at a time between frames.

A frame opens with a start strobe on its first input. The remaining inputs may arrive with idle cycles between them. One cycle after the last input is accepted, a one-cycle done pulse marks the new results.

Top module: `ens_vote_unit`

## Requirements
- R1: While reset is high and after it is released, `out_done`, `out_steer` and `out_collide` are 0, and every model weight holds 0x80 (0.5 in Q0.8).
- R2: A cycle with `wgt_we` high writes `wgt_val` as an unsigned Q0.8 weight into model `wgt_idx`. An index of NUM_MODELS or above writes nothing. A weight not written keeps its value, and a new weight applies to inputs accepted from the next cycle on.
- R3: An input is accepted on a cycle with `in_valid` high. The accepted input that carries `in_start` belongs to model 0, and later accepted inputs belong to models 1 to NUM_MODELS-1 in order. Cycles with `in_valid` low are skipped whatever their data.
- R4: While no frame is open, `in_valid` without `in_start` is ignored: it produces no done pulse and does not affect the next frame.
- R5: `in_start` with `in_valid` in the middle of a frame drops the partial sums and opens a new frame at model 0.
- R6: `out_done` is high for exactly one cycle, namely the cycle after the NUM_MODELS-th accepted input, and is low at every other time.
- R7: At done, `out_steer` equals floor( sum(w_i * x_i) / (256 * NUM_MODELS) ), where x_i is the signed input and w_i is the raw 8-bit weight of model i. Rounding is toward minus infinity.
- R8: At done, `out_collide` is 1 exactly when 2 * (sum of w_i over models whose `in_vote` is 1) >= (sum of all w_i). An exact tie, and also all-zero weights, gives 1.
- R9: Between done pulses, `out_steer` and `out_collide` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wgt_we | input | 1 | Weight write strobe |
| wgt_idx | input | IDX_W | Model number for the weight write |
| wgt_val | input | 8 | Unsigned Q0.8 weight value |
| in_start | input | 1 | Marks the first input of a frame |
| in_valid | input | 1 | Input present this cycle |
| in_steer | input | DATA_W | Signed regression output of the current model |
| in_vote | input | 1 | Class decision of the current model (1 = collision) |
| out_done | output | 1 | One-cycle pulse: results are new |
| out_steer | output | DATA_W | Weighted average steering value |
| out_collide | output | 1 | Weighted hard-vote decision |

## Verification
The main function is exercised with random weights, values and votes, and also with hand-picked frames. Equal weights with all inputs at -1 separate floor rounding from truncation toward zero. The most negative input at the largest weight checks that the accumulator does not overflow. Weights of 0x40 with two of four votes set hit the threshold exactly, and one vote falls just below it; all-zero weights check the degenerate tie. Frames with idle gaps and junk data, stray valid pulses while idle, and a restart halfway through a frame separate correct input counting from simple cycle counting.

// File: rtl/ens_vote_pkg.sv
package ens_vote_pkg;

    localparam int WGT_W    = 8;
    localparam int WGT_FRAC = 8;
    localparam logic [WGT_W-1:0] WGT_RST = 8'h80;

    typedef struct packed {
        logic take;
        logic first;
        logic last;
    } step_t;

    function automatic bit is_pow2(input int n);
        return (n > 0) && ((n & (n - 1)) == 0);
    endfunction

endpackage

// File: rtl/ens_seq_ctrl.sv
module ens_seq_ctrl
    import ens_vote_pkg::*;
#(
    parameter int NUM_MODELS = 4,
    localparam int IDX_W = (NUM_MODELS > 1) ? $clog2(NUM_MODELS) : 1,
    localparam int CNT_W = $clog2(NUM_MODELS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_start,
    input  logic             in_valid,
    output step_t            step,
    output logic [IDX_W-1:0] cur_idx
);
    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        step.first = in_valid && in_start;
        step.take  = in_valid && (in_start || busy_q);
        if (step.first)
            step.last = (NUM_MODELS == 1);
        else
            step.last = step.take && (cnt_q == CNT_W'(NUM_MODELS - 1));
        cur_idx = step.first ? '0 : IDX_W'(cnt_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (step.take) begin
            busy_q <= !step.last;
            cnt_q  <= step.last ? '0 : (step.first ? CNT_W'(1) : cnt_q + CNT_W'(1));
        end
    end

    // R3: an open frame never has counted past the last model
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cnt_q < CNT_W'(NUM_MODELS)));

    // R4: a frame only opens on a start strobe
    p_open_on_start_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> $past(in_start && in_valid));

endmodule

// File: rtl/ens_wgt_bank.sv
module ens_wgt_bank
    import ens_vote_pkg::*;
#(
    parameter int NUM_MODELS = 4,
    localparam int IDX_W = (NUM_MODELS > 1) ? $clog2(NUM_MODELS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wgt_we,
    input  logic [IDX_W-1:0] wgt_idx,
    input  logic [WGT_W-1:0] wgt_val,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WGT_W-1:0] rd_wgt
);
    logic [WGT_W-1:0] wgt_q [NUM_MODELS];

    for (genvar i = 0; i < NUM_MODELS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                wgt_q[i] <= WGT_RST;
            else if (wgt_we && (wgt_idx == IDX_W'(i)))
                wgt_q[i] <= wgt_val;
        end

        // R2: a slot not addressed by a write keeps its weight
        p_keep_r2: assert property (@(posedge clk) disable iff (rst)
            !(wgt_we && (wgt_idx == IDX_W'(i))) |=> $stable(wgt_q[i]));
    end

    always_comb begin
        rd_wgt = '0;
        for (int j = 0; j < NUM_MODELS; j++)
            if (rd_idx == IDX_W'(j))
                rd_wgt = wgt_q[j];
    end

endmodule

// File: rtl/ens_soft_acc.sv
module ens_soft_acc
    import ens_vote_pkg::*;
#(
    parameter int NUM_MODELS = 4,
    parameter int DATA_W     = 12,
    localparam int CNT_W  = $clog2(NUM_MODELS + 1),
    localparam int PROD_W = DATA_W + WGT_W + 1,
    localparam int ACC_W  = PROD_W + CNT_W + 1,
    localparam int DIVISOR = NUM_MODELS << WGT_FRAC
) (
    input  logic                     clk,
    input  logic                     rst,
    input  step_t                    step,
    input  logic signed [DATA_W-1:0] x_in,
    input  logic [WGT_W-1:0]         wgt,
    output logic signed [DATA_W-1:0] avg_out
);
    logic signed [PROD_W-1:0] x_ext, w_ext, term;
    logic signed [ACC_W-1:0]  acc_q, acc_nxt, quot;

    always_comb begin
        x_ext   = {{(PROD_W-DATA_W){x_in[DATA_W-1]}}, x_in};
        w_ext   = {{(PROD_W-WGT_W){1'b0}}, wgt};
        term    = x_ext * w_ext;
        acc_nxt = (step.first ? '0 : acc_q) + {{(ACC_W-PROD_W){term[PROD_W-1]}}, term};
    end

    if (is_pow2(NUM_MODELS)) begin : g_shift
        localparam int SHIFT = WGT_FRAC + $clog2(NUM_MODELS);
        assign quot = acc_nxt >>> SHIFT;
    end else begin : g_div
        localparam logic signed [ACC_W-1:0] DIV_C = ACC_W'(DIVISOR);
        logic signed [ACC_W-1:0] q_trunc, rem;
        always_comb begin
            q_trunc = acc_nxt / DIV_C;
            rem     = acc_nxt - q_trunc * DIV_C;
            quot    = (acc_nxt < 0 && rem != 0) ? q_trunc - ACC_W'(1) : q_trunc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            avg_out <= '0;
        end else if (step.take) begin
            acc_q <= acc_nxt;
            if (step.last)
                avg_out <= quot[DATA_W-1:0];
        end
    end

    // R7: the average of weights below one never leaves the input range
    p_avg_range_r7: assert property (@(posedge clk) disable iff (rst)
        step.last |-> (quot <= ACC_W'((1 << (DATA_W-1)) - 1)) &&
                      (quot >= -ACC_W'(1 << (DATA_W-1))));

endmodule

// File: rtl/ens_hard_acc.sv
module ens_hard_acc
    import ens_vote_pkg::*;
#(
    parameter int NUM_MODELS = 4,
    localparam int CNT_W = $clog2(NUM_MODELS + 1),
    localparam int SUM_W = WGT_W + CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  step_t            step,
    input  logic             vote,
    input  logic [WGT_W-1:0] wgt,
    output logic             decide
);
    logic [SUM_W-1:0] yes_q, yes_nxt, tot_q, tot_nxt;

    always_comb begin
        yes_nxt = (step.first ? '0 : yes_q) + (vote ? SUM_W'(wgt) : '0);
        tot_nxt = (step.first ? '0 : tot_q) + SUM_W'(wgt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            yes_q  <= '0;
            tot_q  <= '0;
            decide <= 1'b0;
        end else if (step.take) begin
            yes_q <= yes_nxt;
            tot_q <= tot_nxt;
            if (step.last)
                decide <= ({yes_nxt, 1'b0} >= {1'b0, tot_nxt});
        end
    end

    // R8: the collision weight is part of the total weight
    p_yes_le_total_r8: assert property (@(posedge clk) disable iff (rst)
        yes_q <= tot_q);

endmodule

// File: rtl/ens_vote_unit.sv
module ens_vote_unit
    import ens_vote_pkg::*;
#(
    parameter int NUM_MODELS = 4,
    parameter int DATA_W     = 12,
    localparam int IDX_W = (NUM_MODELS > 1) ? $clog2(NUM_MODELS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wgt_we,
    input  logic [IDX_W-1:0]  wgt_idx,
    input  logic [7:0]        wgt_val,
    input  logic              in_start,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_steer,
    input  logic              in_vote,
    output logic              out_done,
    output logic [DATA_W-1:0] out_steer,
    output logic              out_collide
);
    step_t            step;
    logic [IDX_W-1:0] cur_idx;
    logic [WGT_W-1:0] cur_wgt;
    logic signed [DATA_W-1:0] avg_s;

    ens_seq_ctrl #(.NUM_MODELS(NUM_MODELS)) u_ctrl (
        .clk(clk), .rst(rst), .in_start(in_start), .in_valid(in_valid),
        .step(step), .cur_idx(cur_idx)
    );

    ens_wgt_bank #(.NUM_MODELS(NUM_MODELS)) u_bank (
        .clk(clk), .rst(rst), .wgt_we(wgt_we), .wgt_idx(wgt_idx),
        .wgt_val(wgt_val), .rd_idx(cur_idx), .rd_wgt(cur_wgt)
    );

    ens_soft_acc #(.NUM_MODELS(NUM_MODELS), .DATA_W(DATA_W)) u_soft (
        .clk(clk), .rst(rst), .step(step), .x_in($signed(in_steer)),
        .wgt(cur_wgt), .avg_out(avg_s)
    );

    ens_hard_acc #(.NUM_MODELS(NUM_MODELS)) u_hard (
        .clk(clk), .rst(rst), .step(step), .vote(in_vote),
        .wgt(cur_wgt), .decide(out_collide)
    );

    assign out_steer = avg_s;

    always_ff @(posedge clk) begin
        if (rst) out_done <= 1'b0;
        else     out_done <= step.last;
    end

    // R6: a done pulse always follows an accepted input
    p_done_after_input_r6: assert property (@(posedge clk) disable iff (rst)
        out_done |-> $past(in_valid));

    // R9: results only move together with a done pulse
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !out_done |-> ($stable(out_steer) && $stable(out_collide)));

endmodule

// File: tb/ens_vote_unit_tb.sv
module ens_vote_unit_tb;
    localparam int K  = 4;
    localparam int DW = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wgt_we = 1'b0;
    logic [1:0] wgt_idx = '0;
    logic [7:0] wgt_val = '0;
    logic in_start = 1'b0, in_valid = 1'b0, in_vote = 1'b0;
    logic [DW-1:0] in_steer = '0;
    logic out_done, out_collide;
    logic [DW-1:0] out_steer;

    int checks = 0;
    int errors = 0;

    logic [7:0]           wv [K];
    logic signed [DW-1:0] fx [K];
    logic                 fv [K];

    always #10 clk = ~clk;

    ens_vote_unit #(.NUM_MODELS(K), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .wgt_we(wgt_we), .wgt_idx(wgt_idx),
        .wgt_val(wgt_val), .in_start(in_start), .in_valid(in_valid),
        .in_steer(in_steer), .in_vote(in_vote), .out_done(out_done),
        .out_steer(out_steer), .out_collide(out_collide)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_avg();
        int s = 0;
        int d = K * 256;
        for (int i = 0; i < K; i++) s += int'(fx[i]) * int'(wv[i]);
        return (s >= 0) ? s / d : -((-s + d - 1) / d);
    endfunction

    function automatic bit exp_col();
        int y = 0;
        int t = 0;
        for (int i = 0; i < K; i++) begin
            t += int'(wv[i]);
            if (fv[i]) y += int'(wv[i]);
        end
        return (2 * y >= t);
    endfunction

    task automatic load_w(input int idx, input logic [7:0] v);
        @(negedge clk);
        wgt_we = 1'b1; wgt_idx = 2'(idx); wgt_val = v;
        @(negedge clk);
        wgt_we = 1'b0;
        wv[idx] = v;
    endtask

    task automatic drive_in(input bit st, input logic signed [DW-1:0] x, input logic v);
        @(negedge clk);
        in_start = st; in_valid = 1'b1; in_steer = x; in_vote = v;
    endtask

    task automatic idle_junk(input int n);
        for (int g = 0; g < n; g++) begin
            @(negedge clk);
            chk(out_done == 1'b0, "R3 gap", int'(out_done), 0);
            in_start = 1'($urandom); in_valid = 1'b0;
            in_steer = DW'($urandom); in_vote = 1'($urandom);
        end
    endtask

    task automatic run_frame(input int gap_max);
        logic [DW-1:0] s_hold;
        logic          c_hold;
        for (int k = 0; k < K; k++) begin
            drive_in(k == 0, fx[k], fv[k]);
            if (k < K - 1 && gap_max > 0) idle_junk(int'($urandom % (gap_max + 1)));
        end
        @(negedge clk);
        in_start = 1'b0; in_valid = 1'b0;
        chk(out_done == 1'b1, "R6 done", int'(out_done), 1);
        chk($signed(out_steer) == exp_avg(), "R7 soft", int'($signed(out_steer)), exp_avg());
        chk(out_collide == exp_col(), "R8 hard", int'(out_collide), int'(exp_col()));
        s_hold = out_steer; c_hold = out_collide;
        @(negedge clk);
        chk(out_done == 1'b0, "R6 single pulse", int'(out_done), 0);
        chk(out_steer == s_hold && out_collide == c_hold, "R9 hold",
            int'(out_steer), int'(s_hold));
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < K; i++) wv[i] = 8'h80;
        repeat (3) @(negedge clk);
        chk(out_done == 0 && out_steer == 0 && out_collide == 0, "R1 in reset",
            int'(out_steer), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_done == 0 && out_steer == 0 && out_collide == 0, "R1 after reset",
            int'(out_done), 0);

        // R1: reset weights 0x80; floor of -512/1024 is -1, not 0 (R7)
        for (int i = 0; i < K; i++) begin fx[i] = -12'sd1; fv[i] = (i == 0); end
        run_frame(0);

        // R2: most negative input at largest weight
        for (int i = 0; i < K; i++) begin load_w(i, 8'hFF); fx[i] = -12'sd2048; fv[i] = 1'b1; end
        run_frame(0);

        // R8: exact tie resolves to 1, one vote below tie gives 0
        for (int i = 0; i < K; i++) begin load_w(i, 8'h40); fx[i] = 12'sd100; end
        fv[0] = 1; fv[1] = 1; fv[2] = 0; fv[3] = 0;
        run_frame(0);
        chk(out_collide == 1'b1, "R8 tie", int'(out_collide), 1);
        fv[1] = 0;
        run_frame(0);
        chk(out_collide == 1'b0, "R8 below", int'(out_collide), 0);

        // R8: all-zero weights give a zero average and a collision
        for (int i = 0; i < K; i++) begin load_w(i, 8'h00); fv[i] = 0; fx[i] = 12'sd2047; end
        run_frame(0);
        chk(out_collide == 1'b1 && out_steer == 0, "R8 zero weights", int'(out_collide), 1);

        // R2: out-of-range write impossible with 2-bit index; single slot write
        load_w(2, 8'hC0);
        for (int i = 0; i < K; i++) begin fx[i] = 12'sd512; fv[i] = (i == 2); end
        run_frame(0);

        // R4: stray valid while idle is ignored
        for (int n = 0; n < 3; n++) begin
            drive_in(1'b0, 12'sd2000, 1'b1);
            @(negedge clk); in_valid = 1'b0;
            chk(out_done == 1'b0, "R4 stray valid", int'(out_done), 0);
        end
        for (int i = 0; i < K; i++) begin load_w(i, 8'(8'h20 + 8'(i * 16))); fx[i] = 12'(i * 300 - 700); fv[i] = i[0]; end
        run_frame(0);

        // R5: restart after two inputs drops the partial frame
        drive_in(1'b1, 12'sd2047, 1'b1);
        drive_in(1'b0, 12'sd2047, 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_done == 1'b0, "R5 no early done", int'(out_done), 0);
        run_frame(0);

        // R3: gaps with junk data, random weights and values
        for (int f = 0; f < 300; f++) begin
            if (f % 5 == 0)
                for (int i = 0; i < K; i++) load_w(i, 8'($urandom));
            for (int i = 0; i < K; i++) begin
                fx[i] = DW'($urandom);
                fv[i] = 1'($urandom);
            end
            run_frame(f % 3);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule